// File: doc/BRIEF.md
# Cycle Master Request and Isochronous Timing Screen

This block serves the link layer of a serial bus node in two ways. First, it decides when the node, acting as cycle master, must ask its transmitter for a cycle-start packet. A request goes out only when the master function is enabled, the node sits at the root of the bus, and the cycle timer reports that its cycle count has advanced. A cycle-timeout event shuts the master function down and keeps it down. Software restarts it by dropping the enable and then raising it again.

Second, it gives a verdict on every incoming isochronous packet. A window opens when a cycle start is observed and closes when the subaction gap follows. In strict mode, packets that arrive while the window is closed are rejected. In lax mode, every packet is accepted. A bus reset closes the window but leaves the timeout latch untouched.

Packet descriptors enter on a valid/ready stream and leave on a second valid/ready stream through a one-entry output register. A descriptor is taken only on a cycle where both `pkt_valid` and `pkt_ready` are high. `pkt_ready` is high whenever the output register is empty or its content is being taken in the same cycle. Once `verd_valid` is high, the verdict holds its value until `verd_ready` takes it. Control and event inputs are plain single-cycle levels or pulses.

Top module: `cm_cycle_master_filter`

## Requirements
- R1: When `master_en`=1, `is_root`=1, the timeout latch is clear and `cyc_timeout`=0, a `cyc_count_inc` pulse produces `cyc_req`=1 for exactly one cycle, on the cycle after the pulse.
- R2: With `master_en`=0 or `is_root`=0, `cyc_count_inc` produces no `cyc_req`.
- R3: A `cyc_timeout` pulse sets a latch, and the latch stays set while `master_en` stays 1. While the latch is set, `master_active` reads 0 and `cyc_count_inc` produces no request.
- R4: The latch clears on any cycle with `master_en`=0, unless `cyc_timeout` is 1 in that cycle. After `master_en` returns to 1, `master_active`=1 and requests resume. `master_active` = `master_en` AND NOT latch.
- R5: The window is closed after reset. `cyc_start_seen` opens it and `subact_gap` closes it, each from the following cycle onward. If both arrive in the same cycle, the window ends up open.
- R6: `bus_reset` closes the window from the following cycle onward and takes priority over `cyc_start_seen`. It does not clear the timeout latch.
- R7: With `strict_mode`=1, a packet taken while the window is closed gets `verd_accept`=0, and a packet taken while the window is open gets `verd_accept`=1.
- R8: With `strict_mode`=0, every packet gets `verd_accept`=1, whatever the window state.
- R9: `pkt_ready` = NOT `verd_valid` OR `verd_ready`. While `verd_valid`=1 and `verd_ready`=0, `verd_valid`, `verd_tag` and `verd_accept` stay stable.
- R10: Each verdict carries the `pkt_tag` of its packet. Verdicts leave in the order the packets were taken, one cycle after the take.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| master_en | input | 1 | Cycle master enable from software |
| is_root | input | 1 | Node is root of the bus |
| strict_mode | input | 1 | 1 = reject packets outside the window |
| cyc_count_inc | input | 1 | Pulse: cycle count advanced |
| cyc_timeout | input | 1 | Pulse: cycle timeout detected |
| cyc_start_seen | input | 1 | Pulse: cycle start observed |
| subact_gap | input | 1 | Pulse: subaction gap observed |
| bus_reset | input | 1 | Pulse: bus reset |
| pkt_valid | input | 1 | Incoming packet descriptor valid |
| pkt_tag | input | TAG_W | Packet descriptor tag |
| pkt_ready | output | 1 | Block can take a descriptor |
| cyc_req | output | 1 | One-cycle cycle-start transmit request |
| master_active | output | 1 | Master function enabled and not latched off |
| verd_valid | output | 1 | Verdict available |
| verd_ready | input | 1 | Downstream takes the verdict |
| verd_tag | output | TAG_W | Tag of the judged packet |
| verd_accept | output | 1 | 1 = accept, 0 = reject |

## Verification
The bench drives a timeout while the enable stays high, checks that requests stay silent through a bus reset, and then restarts the master by toggling the enable. A design that cleared the latch on bus reset, or that ignored the timeout, would emit a request where none is expected. Packets are sent with the window closed, open, reopened after a gap, and closed by a bus reset in both strict and lax modes. A design with the wrong window edges or the wrong mode sense would produce a verdict that disagrees with the scoreboard. Back-pressure bursts check that a held verdict neither changes nor gets lost, and that tags keep their order.

// File: rtl/cm_pkg.sv
package cm_pkg;
  typedef enum logic {
    WIN_CLOSED = 1'b0,
    WIN_OPEN   = 1'b1
  } win_state_e;

  function automatic logic iso_verdict(input logic strict, input win_state_e st);
    return !strict || (st == WIN_OPEN);
  endfunction
endpackage

// File: rtl/cm_master_ctrl.sv
module cm_master_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic master_en,
  input  logic is_root,
  input  logic cyc_count_inc,
  input  logic cyc_timeout,
  output logic cyc_req,
  output logic master_active
);
  logic to_lat;
  logic req_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      to_lat <= 1'b0;
    end else if (cyc_timeout) begin
      to_lat <= 1'b1;
    end else if (!master_en) begin
      to_lat <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q <= 1'b0;
    end else begin
      req_q <= master_en && is_root && cyc_count_inc && !to_lat && !cyc_timeout;
    end
  end

  assign cyc_req       = req_q;
  assign master_active = master_en && !to_lat;

  AST_REQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_req |-> $past(cyc_count_inc && master_en && is_root)); // R1
  AST_REQ_NEEDS_EN_ROOT: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_root || !master_en) |=> !cyc_req); // R2
  AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (to_lat && master_en) |=> to_lat); // R3
  AST_LATCH_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    to_lat |-> !cyc_req); // R3
endmodule

// File: rtl/cm_iso_window.sv
module cm_iso_window
  import cm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cyc_start_seen,
  input  logic       subact_gap,
  input  logic       bus_reset,
  output win_state_e win_state
);
  win_state_e st_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= WIN_CLOSED;
    end else if (bus_reset) begin
      st_q <= WIN_CLOSED;
    end else if (cyc_start_seen) begin
      st_q <= WIN_OPEN;
    end else if (subact_gap) begin
      st_q <= WIN_CLOSED;
    end
  end

  assign win_state = st_q;

  AST_BUSRST_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |=> (win_state == WIN_CLOSED)); // R6
  AST_START_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_start_seen && !bus_reset) |=> (win_state == WIN_OPEN)); // R5
  AST_GAP_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (subact_gap && !cyc_start_seen) |=> (win_state == WIN_CLOSED)); // R5
endmodule

// File: rtl/cm_verdict_stage.sv
module cm_verdict_stage
  import cm_pkg::*;
#(
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strict_mode,
  input  win_state_e       win_state,
  input  logic             pkt_valid,
  input  logic [TAG_W-1:0] pkt_tag,
  output logic             pkt_ready,
  output logic             verd_valid,
  input  logic             verd_ready,
  output logic [TAG_W-1:0] verd_tag,
  output logic             verd_accept
);
  logic             vld_q;
  logic [TAG_W-1:0] tag_q;
  logic             acc_q;
  logic             take;

  assign pkt_ready = !vld_q || verd_ready;
  assign take      = pkt_valid && pkt_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      tag_q <= '0;
      acc_q <= 1'b0;
    end else if (take) begin
      vld_q <= 1'b1;
      tag_q <= pkt_tag;
      acc_q <= iso_verdict(strict_mode, win_state);
    end else if (verd_ready) begin
      vld_q <= 1'b0;
    end
  end

  assign verd_valid  = vld_q;
  assign verd_tag    = tag_q;
  assign verd_accept = acc_q;

  AST_STRICT_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (take && strict_mode && win_state == WIN_CLOSED) |=> (verd_valid && !verd_accept)); // R7
  AST_LAX_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !strict_mode) |=> (verd_valid && verd_accept)); // R8
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (verd_valid && !verd_ready) |=> (verd_valid && $stable(verd_tag) && $stable(verd_accept))); // R9
  AST_TAG_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (verd_tag == $past(pkt_tag))); // R10
endmodule

// File: rtl/cm_cycle_master_filter.sv
module cm_cycle_master_filter
  import cm_pkg::*;
#(
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             master_en,
  input  logic             is_root,
  input  logic             strict_mode,
  input  logic             cyc_count_inc,
  input  logic             cyc_timeout,
  input  logic             cyc_start_seen,
  input  logic             subact_gap,
  input  logic             bus_reset,
  input  logic             pkt_valid,
  input  logic [TAG_W-1:0] pkt_tag,
  output logic             pkt_ready,
  output logic             cyc_req,
  output logic             master_active,
  output logic             verd_valid,
  input  logic             verd_ready,
  output logic [TAG_W-1:0] verd_tag,
  output logic             verd_accept
);
  win_state_e win_state;

  cm_master_ctrl master_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .master_en    (master_en),
    .is_root      (is_root),
    .cyc_count_inc(cyc_count_inc),
    .cyc_timeout  (cyc_timeout),
    .cyc_req      (cyc_req),
    .master_active(master_active)
  );

  cm_iso_window window_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .cyc_start_seen(cyc_start_seen),
    .subact_gap    (subact_gap),
    .bus_reset     (bus_reset),
    .win_state     (win_state)
  );

  cm_verdict_stage #(.TAG_W(TAG_W)) verdict_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .strict_mode(strict_mode),
    .win_state  (win_state),
    .pkt_valid  (pkt_valid),
    .pkt_tag    (pkt_tag),
    .pkt_ready  (pkt_ready),
    .verd_valid (verd_valid),
    .verd_ready (verd_ready),
    .verd_tag   (verd_tag),
    .verd_accept(verd_accept)
  );

  AST_ACTIVE_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_timeout && master_en) |=> !master_active); // R3
endmodule

// File: tb/cm_cycle_master_filter_tb_top.sv
`timescale 1ns/1ps
module cm_cycle_master_filter_tb_top;
  localparam int TAG_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic master_en = 1'b0, is_root = 1'b0, strict_mode = 1'b0;
  logic cyc_count_inc = 1'b0, cyc_timeout = 1'b0, cyc_start_seen = 1'b0;
  logic subact_gap = 1'b0, bus_reset = 1'b0;
  logic pkt_valid = 1'b0;
  logic [TAG_W-1:0] pkt_tag = '0;
  logic verd_ready = 1'b1;
  logic pkt_ready, cyc_req, master_active, verd_valid, verd_accept;
  logic [TAG_W-1:0] verd_tag;

  int checks = 0;
  int failures = 0;
  logic [TAG_W:0] sb_q[$];
  logic toggle_rdy = 1'b0;

  always #2.5 clk = ~clk;

  cm_cycle_master_filter #(.TAG_W(TAG_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .master_en(master_en), .is_root(is_root),
    .strict_mode(strict_mode), .cyc_count_inc(cyc_count_inc),
    .cyc_timeout(cyc_timeout), .cyc_start_seen(cyc_start_seen),
    .subact_gap(subact_gap), .bus_reset(bus_reset), .pkt_valid(pkt_valid),
    .pkt_tag(pkt_tag), .pkt_ready(pkt_ready), .cyc_req(cyc_req),
    .master_active(master_active), .verd_valid(verd_valid),
    .verd_ready(verd_ready), .verd_tag(verd_tag), .verd_accept(verd_accept)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Pulse one event input for one cycle: 0 inc,1 timeout,2 start,3 gap,4 busrst
  task automatic pulse(input int ev);
    @(negedge clk);
    case (ev)
      0: cyc_count_inc = 1'b1;
      1: cyc_timeout = 1'b1;
      2: cyc_start_seen = 1'b1;
      3: subact_gap = 1'b1;
      default: bus_reset = 1'b1;
    endcase
    @(negedge clk);
    cyc_count_inc = 1'b0; cyc_timeout = 1'b0; cyc_start_seen = 1'b0;
    subact_gap = 1'b0; bus_reset = 1'b0;
  endtask

  // Increment pulse, then check the request on the next cycle and silence after
  task automatic inc_and_check(input string req, input logic exp);
    pulse(0);
    #1 check(req, cyc_req, exp);
    @(negedge clk);
    #1 check(req, cyc_req, 1'b0);
  endtask

  task automatic send_pkt(input logic [TAG_W-1:0] t, input logic exp_acc);
    @(negedge clk);
    pkt_valid = 1'b1;
    pkt_tag = t;
    sb_q.push_back({t, exp_acc});
    forever begin
      #2;
      if (pkt_ready) break;
      @(negedge clk);
    end
    @(negedge clk);
    pkt_valid = 1'b0;
  endtask

  // Monitor: compare taken verdicts against the scoreboard (R7, R8, R10)
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (verd_valid && verd_ready) begin
        if (sb_q.size() == 0) begin
          check("R10 unexpected verdict", 1, 0);
        end else begin
          logic [TAG_W:0] e;
          e = sb_q.pop_front();
          check("R10/R7/R8 verdict", {verd_tag, verd_accept}, e);
        end
      end
    end
  end

  always @(negedge clk) if (toggle_rdy) verd_ready = ~verd_ready;

  initial begin
    #150000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R5 reset verd_valid", verd_valid, 0);
    check("R9 reset pkt_ready", pkt_ready, 1);
    check("R1 reset cyc_req", cyc_req, 0);
    check("R4 reset master_active", master_active, 0);

    // R1
    master_en = 1'b1; is_root = 1'b1;
    #1 check("R4 active after enable", master_active, 1);
    inc_and_check("R1 request pulse", 1'b1);
    // R2
    is_root = 1'b0;
    inc_and_check("R2 not root", 1'b0);
    is_root = 1'b1; master_en = 1'b0;
    inc_and_check("R2 not enabled", 1'b0);
    master_en = 1'b1;
    // R3
    pulse(1);
    #1 check("R3 active after timeout", master_active, 0);
    inc_and_check("R3 latched no request", 1'b0);
    // R6 bus reset keeps latch
    pulse(4);
    #1 check("R6 latch kept by bus reset", master_active, 0);
    inc_and_check("R6 latch still blocks", 1'b0);
    // R4 restart
    @(negedge clk); master_en = 1'b0;
    @(negedge clk); master_en = 1'b1;
    #1 check("R4 active after restart", master_active, 1);
    inc_and_check("R4 request after restart", 1'b1);

    // R7 strict mode window tests
    strict_mode = 1'b1;
    send_pkt(8'h01, 1'b0);         // R5 closed after reset
    pulse(2);
    send_pkt(8'h02, 1'b1);         // R7 inside window
    send_pkt(8'h03, 1'b1);
    pulse(3);
    send_pkt(8'h04, 1'b0);         // R5 closed by gap
    pulse(2);
    pulse(4);
    send_pkt(8'h05, 1'b0);         // R6 bus reset closes window
    // R8 lax mode
    strict_mode = 1'b0;
    send_pkt(8'h06, 1'b1);
    pulse(2);
    send_pkt(8'h07, 1'b1);
    pulse(3);

    // R9 back-pressure
    @(negedge clk); verd_ready = 1'b0;
    send_pkt(8'h08, 1'b1);
    repeat (3) begin
      #1;
      check("R9 held valid", verd_valid, 1);
      check("R9 held tag", verd_tag, 8'h08);
      check("R9 ready low", pkt_ready, 0);
      @(negedge clk);
    end
    verd_ready = 1'b1;

    // R10 ordered burst under toggling ready, strict window open
    strict_mode = 1'b1;
    pulse(2);
    toggle_rdy = 1'b1;
    for (int i = 0; i < 6; i++) send_pkt(8'h10 + 8'(i), 1'b1);
    toggle_rdy = 1'b0;
    @(negedge clk); verd_ready = 1'b1;
    repeat (4) @(negedge clk);
    check("R10 scoreboard drained", sb_q.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule